// File: doc/BRIEF.md
# Slot Interrupt Aggregator

The block gathers two interrupt request lines from each of four plug-in module slots and folds them into one host interrupt line. A host reaches it over a simple 16-bit register port at halfword offsets. Every slot owns an 8-bit control register. Two bits of that register enable the slot's lines, and two more choose whether each line is level-sensitive or edge-sensitive. A 16-bit status register holds one pending bit per line, one timeout flag per slot, and four error bits that always read zero.

Level-sensitive lines keep the host interrupt asserted for as long as any of their pending bits stays set. When an edge-sensitive line goes from idle to pending, the host line flips away from its held level for exactly one clock. To acknowledge a line, software writes a one to its pending bit. The block then sends a one-cycle clear strobe back to that slot, and the pending bit drops only when the module releases its request. A timeout flag is cleared directly by writing a one to it.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, every control register, the status register, `rdata`, `clr_o` and `irq_o` are zero.
- R2: Word index w = addr[3:1] in the range 1..4 selects the control register of slot w-1. A write stores wdata[7:0]. A read returns that byte in rdata[7:0], with zeros in rdata[15:8]. Read data appears on `rdata` one cycle after `rd_en`.
- R3: Index 0 (revision) and index 5 (reset command) read zero, as does the unused index 7. Writes to these three indices change no register.
- R4: Status bit 2n+k (slot n, line k) follows `req_i[2n+k]` when enable bit 6+k of slot n's control register is set. When that enable bit is clear, changes on the request line are ignored and the status bit holds its value.
- R5: A line whose control bit 4+k is clear is level-sensitive. `irq_o` goes high in the same clock edge that any level-sensitive pending bit becomes set, and it returns low when none remain set.
- R6: A line whose control bit 4+k is set is edge-sensitive. When its pending bit rises, `irq_o` shows the inverse of the held level for exactly one cycle. When the bit falls, `irq_o` does not change.
- R7: Writing status (index 6) with bit 2n+k set drives `clr_o[2n+k]` high for the one cycle after the write edge. The pending bit itself is not changed by the write.
- R8: A high `tmo_i[n]` sets status bit 12+n. Writing a one to bit 12+n clears it. A set and a clear in the same cycle leave the bit set.
- R9: Status bits 8..11 always read zero. Writing ones to them produces no clear strobe and changes no status bit.
- R10: The held level is recomputed only when a level-sensitive pending bit changes. Pending bits of edge-sensitive lines never hold `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset; bit 0 is ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| req_i | input | 8 | Request lines, index 2*slot+line |
| tmo_i | input | 4 | Per-slot timeout event |
| clr_o | output | 8 | One-cycle clear strobes to the request lines |
| irq_o | output | 1 | Host interrupt |

## Verification
A table walks one slot through a series of control settings and request patterns:
- a disabled line is toggled;
- a level line is raised and then dropped;
- an edge line rises and then falls;
- an edge line rises while a level line already holds the output high.

Together these steps separate held behaviour from pulsed behaviour. They also show whether the pulse is an inversion of the held level or a plain high pulse, and whether an edge line's fall is wrongly treated as a level change.

Directed tests cover the rest:
- two level sources overlapping across slots;
- the acknowledge strobe, and the fact that the pending bit stays set while the request persists;
- a timeout set racing a clear;
- writes to the error bits and to the inert offsets.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int SLOTS    = 4;
  localparam int LINES    = 2;
  localparam int REQS     = SLOTS * LINES;
  localparam int DW       = 16;
  localparam int CW       = 8;
  localparam int AW       = 4;
  localparam int TMO_LSB  = 12;
  localparam int ERR_W    = TMO_LSB - REQS;
  localparam int EDGE_LSB = 4;
  localparam int EN_LSB   = 6;
  localparam int WIX_REV   = 0;
  localparam int WIX_CTRL0 = 1;
  localparam int WIX_STAT  = 6;
  localparam logic [DW-1:0] REV_ID = '0;
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int NSLOT = SLOTS,
  parameter int NLINE = LINES,
  parameter int CTLW  = CW,
  parameter int DATW  = DW,
  parameter int WIXW  = AW - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [WIXW-1:0]          widx,
  input  logic [CTLW-1:0]          wbyte,
  input  logic [DATW-1:0]          status,
  output logic [NSLOT*NLINE-1:0]   en_mask,
  output logic [NSLOT*NLINE-1:0]   edge_mask,
  output logic                     stat_wr,
  output logic [DATW-1:0]          rdata
);
  logic [NSLOT-1:0][CTLW-1:0] ctrl_q;
  logic [DATW-1:0]            rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NSLOT; s++)
        if (widx == WIXW'(WIX_CTRL0 + s)) ctrl_q[s] <= wbyte;
    end
  end

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      for (genvar k = 0; k < NLINE; k++) begin : g_line
        assign en_mask[s*NLINE+k]   = ctrl_q[s][EN_LSB+k];
        assign edge_mask[s*NLINE+k] = ctrl_q[s][EDGE_LSB+k];
      end
    end
  endgenerate

  assign stat_wr = wr_en && (widx == WIXW'(WIX_STAT));

  always_comb begin
    rd_mux = '0;
    if (widx == WIXW'(WIX_REV))  rd_mux = REV_ID;
    if (widx == WIXW'(WIX_STAT)) rd_mux = status;
    for (int s = 0; s < NSLOT; s++)
      if (widx == WIXW'(WIX_CTRL0 + s)) rd_mux = DATW'(ctrl_q[s]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1: the read port comes out of reset empty
  a_r1_rdata_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == '0);
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status
  import irqagg_pkg::*;
#(
  parameter int NREQ  = REQS,
  parameter int NSLOT = SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  req_i,
  input  logic [NSLOT-1:0] tmo_i,
  input  logic [NREQ-1:0]  en_mask,
  input  logic             stat_wr,
  input  logic [NREQ-1:0]  wclr_line,
  input  logic [NSLOT-1:0] wclr_tmo,
  output logic [NREQ-1:0]  line_q,
  output logic [NREQ-1:0]  line_d,
  output logic [NSLOT-1:0] tmo_q,
  output logic [NREQ-1:0]  clr_o
);
  logic [NSLOT-1:0] tmo_d;

  // enabled lines track their request, disabled ones hold
  assign line_d = (req_i & en_mask) | (line_q & ~en_mask);
  // a new timeout event wins over a simultaneous clear
  assign tmo_d  = tmo_i | (tmo_q & ~(stat_wr ? wclr_tmo : '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      tmo_q  <= '0;
      clr_o  <= '0;
    end else begin
      line_q <= line_d;
      tmo_q  <= tmo_d;
      clr_o  <= stat_wr ? wclr_line : '0;
    end
  end

  // R4: a line whose enable was clear keeps its pending bit
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((line_q ^ $past(line_q)) & ~$past(en_mask)) == '0);

  // R8: a timeout event always lands in the flag
  a_r8_tmo_set: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(tmo_i) & ~tmo_q) == '0);
endmodule

// File: rtl/irqagg_merge.sv
module irqagg_merge
  import irqagg_pkg::*;
#(
  parameter int NREQ = REQS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] line_q,
  input  logic [NREQ-1:0] line_d,
  input  logic [NREQ-1:0] edge_mask,
  output logic            irq_o
);
  logic held_q, held_d, pulse_q, pulse_d, lvl_chg;

  assign lvl_chg = |((line_d ^ line_q) & ~edge_mask);
  assign held_d  = lvl_chg ? |(line_d & ~edge_mask) : held_q;
  assign pulse_d = |(line_d & ~line_q & edge_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      pulse_q <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      held_q  <= held_d;
      pulse_q <= pulse_d;
      irq_o   <= held_d ^ pulse_d;
    end
  end

  // R5: without an edge event the output shows the held level
  a_r5_irq_held: assert property (@(posedge clk) disable iff (rst)
    !pulse_q |-> irq_o == held_q);

  // R10: held level moves only when a level-sensitive pending bit moved
  a_r10_held_stable: assert property (@(posedge clk) disable iff (rst)
    (((line_q ^ $past(line_q)) & ~$past(edge_mask)) == '0) |-> $stable(held_q));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [REQS-1:0]  req_i,
  input  logic [SLOTS-1:0] tmo_i,
  output logic [REQS-1:0]  clr_o,
  output logic             irq_o
);
  logic [REQS-1:0]  en_mask, edge_mask, line_q, line_d;
  logic [SLOTS-1:0] tmo_q;
  logic [DW-1:0]    status;
  logic             stat_wr;
  logic             unused_bits;

  assign status      = {tmo_q, {ERR_W{1'b0}}, line_q};
  assign unused_bits = ^{addr[0], wdata[TMO_LSB-1:REQS]};

  irqagg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .widx(addr[AW-1:1]), .wbyte(wdata[CW-1:0]), .status(status),
    .en_mask(en_mask), .edge_mask(edge_mask), .stat_wr(stat_wr), .rdata(rdata)
  );

  irqagg_status u_status (
    .clk(clk), .rst(rst), .req_i(req_i), .tmo_i(tmo_i), .en_mask(en_mask),
    .stat_wr(stat_wr), .wclr_line(wdata[REQS-1:0]),
    .wclr_tmo(wdata[TMO_LSB +: SLOTS]),
    .line_q(line_q), .line_d(line_d), .tmo_q(tmo_q), .clr_o(clr_o)
  );

  irqagg_merge u_merge (
    .clk(clk), .rst(rst), .line_q(line_q), .line_d(line_d),
    .edge_mask(edge_mask), .irq_o(irq_o)
  );
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  req_i = '0;
  logic [3:0]  tmo_i = '0;
  logic [7:0]  clr_o;
  logic        irq_o;
  int total = 0, bad = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  irq_aggregator uut (.*);

  // {ctrl A, req[1:0], expected status[1:0], irq after 1 cycle, irq after 2}
  localparam logic [13:0] VEC [10] = '{
    {8'h00, 2'b01, 2'b00, 1'b0, 1'b0},  // R4 disabled line ignored
    {8'h40, 2'b01, 2'b01, 1'b1, 1'b1},  // R5 level asserts
    {8'h40, 2'b00, 2'b00, 1'b0, 1'b0},  // R5 level deasserts
    {8'h50, 2'b01, 2'b01, 1'b1, 1'b0},  // R6 edge pulse from low
    {8'h50, 2'b00, 2'b00, 1'b0, 1'b0},  // R6 falling edge silent
    {8'h80, 2'b10, 2'b10, 1'b1, 1'b1},  // R5 line 1 level
    {8'hD0, 2'b11, 2'b11, 1'b0, 1'b1},  // R6 inverted pulse while held
    {8'hD0, 2'b01, 2'b01, 1'b0, 1'b0},  // R10 edge pending does not hold
    {8'h00, 2'b00, 2'b01, 1'b0, 1'b0},  // R4 disabled holds pending
    {8'h40, 2'b00, 2'b00, 1'b0, 1'b0}   // R4 re-enable follows request
  };

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'd0, irq_o}, 16'd0);
    check("R1 clr", {8'd0, clr_o}, 16'd0);
    check("R1 rdata", rdata, 16'd0);
    for (int i = 1; i <= 4; i++) begin
      rd(4'(2*i), rv);
      check("R1 ctrl", rv, 16'd0);
    end
    rd(4'hC, rv); check("R1 status", rv, 16'd0);

    // vector walk on slot A
    for (int v = 0; v < 10; v++) begin
      logic [13:0] e;
      e = VEC[v];
      wr(4'h2, {8'h00, e[13:6]});
      req_i[1:0] = e[5:4];
      @(negedge clk);
      check($sformatf("R5/R6 vec%0d irq1", v), {15'd0, irq_o}, {15'd0, e[1]});
      @(negedge clk);
      check($sformatf("R5/R6 vec%0d irq2", v), {15'd0, irq_o}, {15'd0, e[0]});
      rd(4'hC, rv);
      check($sformatf("R4 vec%0d status", v), rv, {14'd0, e[3:2]});
    end

    // R2 control register readback and slot decode
    wr(4'h6, 16'hABCD);
    rd(4'h6, rv); check("R2 slot C byte", rv, 16'h00CD);
    rd(4'h8, rv); check("R2 slot D untouched", rv, 16'h0000);
    rd(4'h2, rv); check("R2 slot A kept", rv, 16'h0040);
    wr(4'h6, 16'h0000);

    // R3 inert offsets
    wr(4'h0, 16'hFFFF); wr(4'hA, 16'hFFFF); wr(4'hE, 16'hFFFF);
    rd(4'h0, rv); check("R3 revision", rv, 16'h0000);
    rd(4'hA, rv); check("R3 reset reg", rv, 16'h0000);
    rd(4'hE, rv); check("R3 reserved", rv, 16'h0000);
    rd(4'h2, rv); check("R3 ctrl A unchanged", rv, 16'h0040);
    rd(4'hC, rv); check("R3 status unchanged", rv, 16'h0000);
    check("R3 irq", {15'd0, irq_o}, 16'd0);

    // R5 overlapping level sources, R7 acknowledge strobe
    wr(4'h4, 16'h0040);
    req_i[2] = 1'b1;
    @(negedge clk);
    check("R5 slot B level", {15'd0, irq_o}, 16'd1);
    req_i[0] = 1'b1;
    @(negedge clk);
    wr(4'hC, 16'h0005);
    check("R7 clr strobe", {8'd0, clr_o}, 16'h0005);
    @(negedge clk);
    check("R7 clr one cycle", {8'd0, clr_o}, 16'h0000);
    rd(4'hC, rv); check("R7 pending kept", rv, 16'h0005);
    req_i[2] = 1'b0;
    @(negedge clk);
    check("R5 still held by slot A", {15'd0, irq_o}, 16'd1);
    req_i[0] = 1'b0;
    @(negedge clk);
    check("R5 released", {15'd0, irq_o}, 16'd0);

    // R8 timeout flags
    tmo_i = 4'b0010;
    @(negedge clk);
    tmo_i = 4'b0000;
    rd(4'hC, rv); check("R8 timeout set", rv, 16'h2000);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'hC; wdata = 16'h8000; tmo_i = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; tmo_i = 4'b0000;
    rd(4'hC, rv); check("R8 set beats clear", rv, 16'hA000);
    wr(4'hC, 16'hA000);
    rd(4'hC, rv); check("R8 cleared", rv, 16'h0000);
    check("R8 no irq", {15'd0, irq_o}, 16'd0);

    // R9 error bits
    wr(4'hC, 16'h0F00);
    check("R9 no strobe", {8'd0, clr_o}, 16'h0000);
    rd(4'hC, rv); check("R9 error bits zero", rv, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule